// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This block is an integer multiplier whose 64-bit result lives in a pair of architectural registers, HI (upper half) and LO (lower half). A three-bit operation code picks one of three kinds of work, each in a signed and an unsigned variant:
- a plain multiply that replaces HI/LO with the product;
- a multiply-add that adds the product to the current {HI,LO};
- a multiply-subtract that takes the product away from the current {HI,LO}.

The product is formed by a shift-add engine that retires one multiplier bit per clock. An operation therefore takes one clock per operand bit.

A processor pipeline uses the unit as follows. It raises `start` with the operands and the operation code for one cycle, watches `busy`, and picks up the new HI/LO after the one-cycle `done` pulse. While the unit is idle, software can also load HI or LO directly through two write-enable ports. Accumulation is plain two's-complement arithmetic modulo 2^64.

Top module: `hilo_mac`

## Requirements
- R1: After reset, `hi_rd`, `lo_rd`, `busy` and `done` are all zero.
- R2: Operation code 3'b000 is a signed multiply. Both operands are sign-extended, HI/LO is overwritten with the 64-bit product, HI receives product bits 63:32 and LO receives bits 31:0.
- R3: Operation code 3'b001 is an unsigned multiply. Both operands are zero-extended and HI/LO is overwritten with the product.
- R4: Operation codes 3'b010 (signed) and 3'b011 (unsigned) add the matching product to the current {HI,LO}.
- R5: Operation codes 3'b100 (signed) and 3'b101 (unsigned) subtract the matching product from the current {HI,LO}.
- R6: Accumulation and subtraction wrap modulo 2^64, with no flag and no saturation.
- R7: Timing of an accepted start:
  - `busy` is high for exactly 32 cycles after the accepting edge.
  - HI/LO change at the edge where `busy` falls.
  - `done` is high for exactly that one following cycle.
- R8: A `start` while `busy` is high is ignored. The running operation finishes with its own operands and operation code.
- R9: A `start` with a reserved operation code (3'b110 or 3'b111) is ignored: `busy` stays low and HI/LO are unchanged.
- R10: When the unit is idle, `hi_we` loads `hi_wdata` into HI and `lo_we` loads `lo_wdata` into LO at the next edge. While `busy` is high, both write enables are ignored.
- R11: HI/LO never change while an operation runs, except at its completing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new operation this cycle |
| op | input | 3 | Operation code; bit 0 set means unsigned, bits 2:1 pick multiply, add or subtract |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: HI/LO were just updated by an operation |
| hi_we | input | 1 | Direct load of HI when idle |
| hi_wdata | input | 32 | Value for a direct HI load |
| lo_we | input | 1 | Direct load of LO when idle |
| lo_wdata | input | 32 | Value for a direct LO load |
| hi_rd | output | 32 | Current HI |
| lo_rd | output | 32 | Current LO |

## Verification
The bound checker watches the handshake on every cycle:
- an accepted start raises `busy`, and a reserved code leaves it low;
- `done` lasts one cycle, never overlaps `busy`, and always follows a run of exactly 32 busy cycles;
- HI/LO hold steady during a run;
- an idle direct load lands in the register.

The arithmetic can only be shown by the bench's scenarios, which compare HI/LO against a behavioural model on every clock. These scenarios cover:
- the signed and unsigned product of extreme operands;
- add and subtract from a preloaded {HI,LO}, including wrap-around through 2^64;
- a second start and direct writes issued in the middle of a run.

// File: rtl/hilo_mac_pkg.sv
package hilo_mac_pkg;

    // Bits 2:1 of the operation code select the kind of work.
    typedef enum logic [1:0] {
        KIND_MUL = 2'b00,
        KIND_ADD = 2'b01,
        KIND_SUB = 2'b10,
        KIND_RSV = 2'b11
    } hm_kind_e;

    function automatic logic op_is_valid(input logic [2:0] op_code);
        return op_code[2:1] != 2'b11;
    endfunction

endpackage

// File: rtl/hilo_mac_core.sv
// Iterative shift-add multiplier: one multiplier bit per clock over W clocks.
// Signed operands are converted to magnitudes up front and the sign is
// applied to the final sum.
module hilo_mac_core
    import hilo_mac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [W-1:0]       go_a,
    input  logic [W-1:0]       go_b,
    input  logic               go_signed,
    input  hm_kind_e           go_kind,
    output logic               busy,
    output logic               fin,
    output hm_kind_e           run_kind,
    output logic [2*W-1:0]     prod
);
    localparam int PW = 2 * W;
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic           busy;
        logic [CW-1:0]  cnt;
        logic [PW-1:0]  mcand;
        logic [W-1:0]   mplier;
        logic [PW-1:0]  sum;
        logic           neg;
        hm_kind_e       kind;
    } core_s;

    core_s core_d, core_q;
    logic [PW-1:0] partial;

    function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic sgn);
        return (sgn && v[W-1]) ? (~v + W'(1)) : v;
    endfunction

    always_comb begin
        core_d  = core_q;
        fin     = 1'b0;
        partial = core_q.sum + (core_q.mplier[0] ? core_q.mcand : '0);
        if (!core_q.busy) begin
            if (go) begin
                core_d.busy   = 1'b1;
                core_d.cnt    = '0;
                core_d.mcand  = {{W{1'b0}}, magnitude(go_a, go_signed)};
                core_d.mplier = magnitude(go_b, go_signed);
                core_d.sum    = '0;
                core_d.neg    = go_signed & (go_a[W-1] ^ go_b[W-1]);
                core_d.kind   = go_kind;
            end
        end else begin
            core_d.sum    = partial;
            core_d.mcand  = core_q.mcand << 1;
            core_d.mplier = core_q.mplier >> 1;
            core_d.cnt    = core_q.cnt + CW'(1);
            if (core_q.cnt == LAST) begin
                core_d.busy = 1'b0;
                fin         = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign busy     = core_q.busy;
    assign run_kind = core_q.kind;
    assign prod     = core_q.neg ? (~partial + PW'(1)) : partial;

endmodule

// File: rtl/hilo_mac_acc.sv
// Combines the finished product with the current {HI,LO}, modulo 2^(2W).
module hilo_mac_acc
    import hilo_mac_pkg::*;
#(
    parameter int W = 32
) (
    input  hm_kind_e        kind,
    input  logic [2*W-1:0]  prod,
    input  logic [2*W-1:0]  cur,
    output logic [2*W-1:0]  nxt
);
    always_comb begin
        unique case (kind)
            KIND_MUL: nxt = prod;
            KIND_ADD: nxt = cur + prod;
            KIND_SUB: nxt = cur - prod;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/hilo_mac_regs.sv
// HI/LO register pair with a completion load and idle-time direct writes.
module hilo_mac_regs #(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_en,
    input  logic [2*W-1:0]  ld_val,
    input  logic            wr_ok,
    input  logic            hi_we,
    input  logic [W-1:0]    hi_wd,
    input  logic            lo_we,
    input  logic [W-1:0]    lo_wd,
    output logic [W-1:0]    hi,
    output logic [W-1:0]    lo,
    output logic            done
);
    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        logic         done;
    } regs_s;

    regs_s regs_d, regs_q;

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = ld_en;
        if (ld_en) begin
            {regs_d.hi, regs_d.lo} = ld_val;
        end else if (wr_ok) begin
            if (hi_we) regs_d.hi = hi_wd;
            if (lo_we) regs_d.lo = lo_wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign hi   = regs_q.hi;
    assign lo   = regs_q.lo;
    assign done = regs_q.done;
endmodule

// File: rtl/hilo_mac.sv
module hilo_mac
    import hilo_mac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    output logic          busy,
    output logic          done,
    input  logic          hi_we,
    input  logic [W-1:0]  hi_wdata,
    input  logic          lo_we,
    input  logic [W-1:0]  lo_wdata,
    output logic [W-1:0]  hi_rd,
    output logic [W-1:0]  lo_rd
);
    logic           accept;
    logic           fin;
    hm_kind_e       run_kind;
    logic [2*W-1:0] prod;
    logic [2*W-1:0] acc_nxt;

    assign accept = start & ~busy & op_is_valid(op);

    hilo_mac_core #(.W(W)) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (accept),
        .go_a      (opa),
        .go_b      (opb),
        .go_signed (~op[0]),
        .go_kind   (hm_kind_e'(op[2:1])),
        .busy      (busy),
        .fin       (fin),
        .run_kind  (run_kind),
        .prod      (prod)
    );

    hilo_mac_acc #(.W(W)) acc_i (
        .kind (run_kind),
        .prod (prod),
        .cur  ({hi_rd, lo_rd}),
        .nxt  (acc_nxt)
    );

    hilo_mac_regs #(.W(W)) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (fin),
        .ld_val (acc_nxt),
        .wr_ok  (~busy),
        .hi_we  (hi_we),
        .hi_wd  (hi_wdata),
        .lo_we  (lo_we),
        .lo_wd  (lo_wdata),
        .hi     (hi_rd),
        .lo     (lo_rd),
        .done   (done)
    );
endmodule

// File: rtl/hilo_mac_chk.sv
module hilo_mac_chk #(
    parameter int W = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [2:0]    op,
    input logic [W-1:0]  opa,
    input logic [W-1:0]  opb,
    input logic          busy,
    input logic          done,
    input logic          hi_we,
    input logic [W-1:0]  hi_wdata,
    input logic          lo_we,
    input logic [W-1:0]  lo_wdata,
    input logic [W-1:0]  hi_rd,
    input logic [W-1:0]  lo_rd
);
    localparam int RLW = $clog2(W + 2) + 1;
    logic [RLW-1:0] run_len;

    // Counts edges at which busy was high; cleared once busy is low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + RLW'(1);
        else           run_len <= '0;
    end

    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && op[2:1] != 2'b11) |=> busy); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7
    AST_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == RLW'(W))); // R7
    AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done)); // R8
    AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && op[2:1] == 2'b11) |=> !busy); // R9
    AST_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && hi_we) |=> (hi_rd == $past(hi_wdata))); // R10
    AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && lo_we) |=> (lo_rd == $past(lo_wdata))); // R10
    AST_HILO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (done || ($stable(hi_rd) && $stable(lo_rd)))); // R11
endmodule

bind hilo_mac hilo_mac_chk #(.W(W)) chk_i (.*);

// File: tb/hilo_mac_tb_top.sv
`timescale 1ns/1ps
module hilo_mac_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] opa = '0, opb = '0;
    logic        hi_we = 1'b0, lo_we = 1'b0;
    logic [31:0] hi_wdata = '0, lo_wdata = '0;
    logic        busy, done;
    logic [31:0] hi_rd, lo_rd;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    hilo_mac dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
        .busy(busy), .done(done), .hi_we(hi_we), .hi_wdata(hi_wdata),
        .lo_we(lo_we), .lo_wdata(lo_wdata), .hi_rd(hi_rd), .lo_rd(lo_rd)
    );

    // Behavioural reference model
    logic [31:0] m_hi = '0, m_lo = '0;
    logic        m_busy = 1'b0, m_done = 1'b0;
    int          m_cnt = 0;
    logic [2:0]  m_op = '0;
    logic [31:0] m_a = '0, m_b = '0;

    function automatic logic [63:0] model_calc(input logic [2:0] o, input logic [31:0] a, b,
                                              input logic [63:0] cur);
        logic [63:0] p;
        if (o[0]) p = {32'b0, a} * {32'b0, b};
        else      p = {{32{a[31]}}, a} * {{32{b[31]}}, b};
        case (o[2:1])
            2'b00:   return p;
            2'b01:   return cur + p;
            default: return cur - p;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hi = '0; m_lo = '0; m_busy = 0; m_done = 0; m_cnt = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    {m_hi, m_lo} = model_calc(m_op, m_a, m_b, {m_hi, m_lo});
                    m_busy = 0;
                    m_done = 1;
                end
            end else begin
                if (hi_we) m_hi = hi_wdata;
                if (lo_we) m_lo = lo_wdata;
                if (start && op[2:1] != 2'b11) begin
                    m_busy = 1; m_cnt = 32; m_op = op; m_a = opa; m_b = opb;
                end
            end
        end
    end

    task automatic cmp(input string what, input logic [31:0] act, exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h at cycle %0d", cur_req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cmp("hi_rd", hi_rd, m_hi);
        cmp("lo_rd", lo_rd, m_lo);
        cmp("busy", {31'b0, busy}, {31'b0, m_busy});
        cmp("done", {31'b0, done}, {31'b0, m_done});
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    // Independent scenario check against hand-derived values
    task automatic chk_hilo(input string tag, input logic [31:0] eh, el);
        compared++;
        if (hi_rd !== eh || lo_rd !== el) begin
            mismatched++;
            $display("FAIL %s scenario: actual %h_%h expected %h_%h", tag, hi_rd, lo_rd, eh, el);
        end
    endtask

    task automatic load(input logic [31:0] h, l);
        @(negedge clk);
        hi_we = 1; lo_we = 1; hi_wdata = h; lo_wdata = l;
        @(negedge clk);
        hi_we = 0; lo_we = 0;
    endtask

    task automatic run_op(input logic [2:0] o, input logic [31:0] a, b);
        @(negedge clk);
        start = 1; op = o; opa = a; opb = b;
        @(negedge clk);
        start = 0;
        repeat (33) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk_hilo("R1", 32'h0, 32'h0);
        rst_n = 1;

        cur_req = "R10";
        load(32'h1234_5678, 32'h9ABC_DEF0);
        chk_hilo("R10", 32'h1234_5678, 32'h9ABC_DEF0);

        cur_req = "R2";
        run_op(3'b000, 32'hFFFF_FFFD, 32'd7);
        chk_hilo("R2", 32'hFFFF_FFFF, 32'hFFFF_FFEB);
        run_op(3'b000, 32'h8000_0000, 32'h8000_0000);
        chk_hilo("R2", 32'h4000_0000, 32'h0);

        cur_req = "R3";
        run_op(3'b001, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk_hilo("R3", 32'hFFFF_FFFE, 32'h0000_0001);

        cur_req = "R4";
        load(32'h0, 32'd5);
        run_op(3'b010, 32'hFFFF_FFFE, 32'd3);
        chk_hilo("R4", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        load(32'h0, 32'd5);
        run_op(3'b011, 32'hFFFF_FFFE, 32'd3);
        chk_hilo("R4", 32'h0000_0002, 32'hFFFF_FFFF);

        cur_req = "R5";
        load(32'h0, 32'h0);
        run_op(3'b100, 32'd2, 32'd3);
        chk_hilo("R5", 32'hFFFF_FFFF, 32'hFFFF_FFFA);
        load(32'h0, 32'h0);
        run_op(3'b101, 32'hFFFF_FFFF, 32'd1);
        chk_hilo("R5", 32'hFFFF_FFFF, 32'h0000_0001);

        cur_req = "R6";
        load(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op(3'b011, 32'd1, 32'd1);
        chk_hilo("R6", 32'h0, 32'h0);

        cur_req = "R9";
        load(32'hAAAA_0000, 32'h0000_5555);
        run_op(3'b110, 32'd9, 32'd9);
        run_op(3'b111, 32'd9, 32'd9);
        chk_hilo("R9", 32'hAAAA_0000, 32'h0000_5555);

        // Second start and direct writes in the middle of a run
        cur_req = "R8";
        load(32'h0, 32'h0);
        @(negedge clk);
        start = 1; op = 3'b001; opa = 32'd6; opb = 32'd7;
        @(negedge clk);
        start = 0;
        repeat (5) @(negedge clk);
        start = 1; op = 3'b000; opa = 32'd100; opb = 32'd100;
        cur_req = "R10";
        hi_we = 1; lo_we = 1; hi_wdata = 32'hDEAD_BEEF; lo_wdata = 32'hCAFE_F00D;
        @(negedge clk);
        start = 0; hi_we = 0; lo_we = 0;
        cur_req = "R11";
        repeat (30) @(negedge clk);
        chk_hilo("R8", 32'h0, 32'd42);

        // Back-to-back accumulations with varied operands
        cur_req = "R7";
        for (int i = 0; i < 24; i++) begin
            logic [2:0] o;
            o = 3'(i % 6);
            @(negedge clk);
            start = 1; op = o; opa = $urandom; opb = $urandom;
            @(negedge clk);
            start = 0;
            repeat (32) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        summary();
    end
endmodule